// File: doc/BRIEF.md
# Interrupt-to-DMA Request Steering Unit

This block sits between the interrupt lines of on-chip peripherals and two consumers: the CPU interrupt controller and a multi-channel DMA engine. Each DMA channel picks one peripheral interrupt source. A per-channel enable bit decides where that source goes. With the bit clear, the source reaches the CPU as a normal interrupt. With the bit set, the source activates the channel instead. A single master-enable bit gates activation on every channel at once.

When a channel is enabled but the master-enable bit is clear, the channel is halted. Its source then reaches neither the DMA engine nor the CPU. A non-maskable interrupt clears the master-enable bit, and so halts all DMA activity. Software then chooses between two ways out. Clearing the channel enable bit hands the source back to the CPU. Setting the master-enable bit again resumes DMA activation.

The unit detects the rising edge of each selected interrupt level and issues single-cycle activation pulses. It tracks a busy flag per channel until the engine reports that the transfer is done. An activation that arrives while a transfer is still running sets a sticky error flag. That flag locks the channel out until its enable bit is cleared.

Top module: `irq_dma_steer`

## Requirements
- R1: After reset, every control bit is 0. Every source level is copied to `cpu_irq_o`, `dma_req_o` is 0, and all busy and error flags are 0.
- R2: Take a source that no enabled channel selects. Its level appears on `cpu_irq_o` in the same cycle, through combinational logic.
- R3: Take a source that at least one channel with its enable bit at 1 selects. That source is held at 0 on `cpu_irq_o`, whatever the value of the master-enable bit.
- R4: Take a channel whose enable bit and master-enable bit are both 1, and which is neither busy nor in error. A 0-to-1 transition of its selected source, sampled at a clock edge, makes `dma_req_o[c]` high for exactly the one cycle that follows that edge.
- R5: While the master-enable bit is 0, no channel raises `dma_req_o`, and rising edges on its source set neither busy nor error.
- R6: `nmi_i` high at a clock edge clears the master-enable bit. If a register write sets the master-enable bit in the same cycle, `nmi_i` takes priority.
- R7: Clearing the enable bit of a halted channel restores delivery of its source to `cpu_irq_o`.
- R8: A single rising edge on one source activates, in the same cycle, every ready channel that selects that source.
- R9: `ch_busy_o[c]` is set in the same edge as the activation pulse. It is cleared by `xfer_done_i[c]` high at a clock edge.
- R10: A rising edge on the selected source of a busy channel sets `ch_err_o[c]`, and no pulse is issued. While the error flag is set, no activation is accepted. The error flag and the busy flag are cleared in the edge that follows a cycle in which the channel enable bit is 0.
- R11: Writing the master-enable bit back to 1 resumes activation on every enabled channel that has no error.
- R12: A source level held high produces only one activation pulse.
- R13: Register map, with a write taking effect at the clock edge where `wr_en_i` is high. Address 0 holds the master-enable bit in data bit 0. Address 1+c holds channel c: data bit 0 is the enable bit, and data bits [SEL_W:1] are the source number. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| nmi_i | input | 1 | Non-maskable interrupt; clears master enable |
| src_irq_i | input | N_SRC | Peripheral interrupt levels |
| xfer_done_i | input | N_CH | Transfer-done pulses from the DMA engine |
| cpu_irq_o | output | N_SRC | Interrupt levels forwarded to the CPU |
| dma_req_o | output | N_CH | Single-cycle activation pulses per channel |
| ch_busy_o | output | N_CH | Channel transfer in progress |
| ch_err_o | output | N_CH | Sticky overrun error per channel |

## Verification
The bench builds the block with N_SRC=4 and N_CH=2. This makes SEL_W 2 and ADDR_W 2, so address 3 is an unused slot that exercises the ignored-write case. At this size a full sweep is possible. It covers every combination of channel, source select, channel enable and master enable, and checks CPU routing, pulse shape and busy handling against arithmetic expectations. Two channels are enough to show one source activating both channels at once. They also show a disabled neighbour leaving a source to the CPU while the other channel claims a different one.

// File: rtl/irq_dma_steer_pkg.sv
package irq_dma_steer_pkg;
  localparam int unsigned GLB_ADDR = 0;   // master-enable register
  localparam int unsigned CH_BASE  = 1;   // first channel register
  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned SEL_LSB  = 1;

  function automatic int unsigned sel_width(int unsigned n_src);
    return (n_src > 1) ? $clog2(n_src) : 1;
  endfunction
endpackage

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
  import irq_dma_steer_pkg::*;
#(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic                        nmi_i,
  output logic                        run_o,
  output logic [N_CH-1:0]             ch_en_o,
  output logic [N_CH-1:0][SEL_W-1:0]  ch_sel_o
);
  logic                       run_q;
  logic [N_CH-1:0]            en_q;
  logic [N_CH-1:0][SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
    end else if (nmi_i) begin
      run_q <= 1'b0;  // nmi beats a same-cycle write
    end else if (wr_en_i && wr_addr_i == ADDR_W'(GLB_ADDR)) begin
      run_q <= wr_data_i[RUN_BIT];
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[c]  <= 1'b0;
        sel_q[c] <= '0;
      end else if (wr_en_i && wr_addr_i == ADDR_W'(CH_BASE + c)) begin
        en_q[c]  <= wr_data_i[EN_BIT];
        sel_q[c] <= wr_data_i[SEL_LSB +: SEL_W];
      end
    end
  end

  assign run_o    = run_q;
  assign ch_en_o  = en_q;
  assign ch_sel_o = sel_q;
endmodule

// File: rtl/irq_steer_edge.sv
module irq_steer_edge #(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  output logic [N_SRC-1:0] rise_o
);
  logic [N_SRC-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_i;
  end

  assign rise_o = src_i & ~src_q;
endmodule

// File: rtl/irq_steer_chan.sv
module irq_steer_chan #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_SRC-1:0] rise_i,
  input  logic             done_i,
  output logic             req_o,
  output logic             busy_o,
  output logic             err_o
);
  logic hit, accept, overrun;
  logic req_q, busy_q, err_q;

  always_comb begin
    hit = 1'b0;
    for (int s = 0; s < N_SRC; s++) begin
      if (sel_i == SEL_W'(s)) hit = hit | rise_i[s];
    end
  end

  assign accept  = en_i & run_i & hit & ~busy_q & ~err_q;
  assign overrun = en_i & run_i & hit & busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      req_q <= accept;
      if (!en_i) begin
        busy_q <= 1'b0;  // disabling abandons the channel state
        err_q  <= 1'b0;
      end else begin
        if (accept)      busy_q <= 1'b1;
        else if (done_i) busy_q <= 1'b0;
        if (overrun)     err_q  <= 1'b1;
      end
    end
  end

  assign req_o  = req_q;
  assign busy_o = busy_q;
  assign err_o  = err_q;
endmodule

// File: rtl/irq_steer_route.sv
module irq_steer_route #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned N_CH  = 4,
  parameter int unsigned SEL_W = 2
) (
  input  logic [N_SRC-1:0]            src_i,
  input  logic [N_CH-1:0]             ch_en_i,
  input  logic [N_CH-1:0][SEL_W-1:0]  ch_sel_i,
  output logic [N_SRC-1:0]            cpu_irq_o
);
  logic [N_SRC-1:0] claimed;

  always_comb begin
    claimed = '0;
    for (int s = 0; s < N_SRC; s++) begin
      for (int c = 0; c < N_CH; c++) begin
        if (ch_en_i[c] && ch_sel_i[c] == SEL_W'(s)) claimed[s] = 1'b1;
      end
    end
  end

  assign cpu_irq_o = src_i & ~claimed;
endmodule

// File: rtl/irq_dma_steer.sv
module irq_dma_steer
  import irq_dma_steer_pkg::*;
#(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned N_CH   = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SEL_W  = sel_width(N_SRC),
  localparam int unsigned ADDR_W = $clog2(N_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              nmi_i,
  input  logic [N_SRC-1:0]  src_irq_i,
  input  logic [N_CH-1:0]   xfer_done_i,
  output logic [N_SRC-1:0]  cpu_irq_o,
  output logic [N_CH-1:0]   dma_req_o,
  output logic [N_CH-1:0]   ch_busy_o,
  output logic [N_CH-1:0]   ch_err_o
);
  logic                       run_q;
  logic [N_CH-1:0]            ch_en;
  logic [N_CH-1:0][SEL_W-1:0] ch_sel;
  logic [N_SRC-1:0]           rise;

  irq_steer_regs #(
    .N_CH(N_CH), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .nmi_i     (nmi_i),
    .run_o     (run_q),
    .ch_en_o   (ch_en),
    .ch_sel_o  (ch_sel)
  );

  irq_steer_edge #(.N_SRC(N_SRC)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_irq_i),
    .rise_o (rise)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    irq_steer_chan #(.N_SRC(N_SRC), .SEL_W(SEL_W)) i_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (ch_en[c]),
      .run_i  (run_q),
      .sel_i  (ch_sel[c]),
      .rise_i (rise),
      .done_i (xfer_done_i[c]),
      .req_o  (dma_req_o[c]),
      .busy_o (ch_busy_o[c]),
      .err_o  (ch_err_o[c])
    );
  end

  irq_steer_route #(.N_SRC(N_SRC), .N_CH(N_CH), .SEL_W(SEL_W)) i_route (
    .src_i     (src_irq_i),
    .ch_en_i   (ch_en),
    .ch_sel_i  (ch_sel),
    .cpu_irq_o (cpu_irq_o)
  );
endmodule

// File: rtl/irq_dma_steer_chk.sv
module irq_dma_steer_chk #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned N_CH  = 4,
  parameter int unsigned SEL_W = 2
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       nmi_i,
  input logic                       run_q,
  input logic [N_CH-1:0]            ch_en,
  input logic [N_CH-1:0][SEL_W-1:0] ch_sel,
  input logic [N_SRC-1:0]           src_irq_i,
  input logic [N_SRC-1:0]           cpu_irq_o,
  input logic [N_CH-1:0]            dma_req_o,
  input logic [N_CH-1:0]            ch_busy_o,
  input logic [N_CH-1:0]            ch_err_o
);
  assert_nmi_halts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |=> !run_q);

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    assert_claimed_src_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_en[c] && src_irq_i[ch_sel[c]]) |-> !cpu_irq_o[ch_sel[c]]);

    assert_req_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_req_o[c] |=> !dma_req_o[c]);

    assert_halt_no_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_q |=> !dma_req_o[c]);

    assert_req_marks_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_req_o[c] |-> ch_busy_o[c]);

    assert_err_blocks_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_err_o[c] |=> !dma_req_o[c]);

    assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_err_o[c] && ch_en[c]) |=> ch_err_o[c]);
  end
endmodule

bind irq_dma_steer irq_dma_steer_chk #(
  .N_SRC(N_SRC), .N_CH(N_CH), .SEL_W(SEL_W)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .nmi_i     (nmi_i),
  .run_q     (run_q),
  .ch_en     (ch_en),
  .ch_sel    (ch_sel),
  .src_irq_i (src_irq_i),
  .cpu_irq_o (cpu_irq_o),
  .dma_req_o (dma_req_o),
  .ch_busy_o (ch_busy_o),
  .ch_err_o  (ch_err_o)
);

// File: tb/test_irq_dma_steer.sv
module test_irq_dma_steer;
  localparam int N_SRC = 4;
  localparam int N_CH  = 2;
  localparam int DW    = 8;
  localparam int AW    = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          nmi = 1'b0;
  logic [N_SRC-1:0] src = '0;
  logic [N_CH-1:0]  done = '0;
  logic [N_SRC-1:0] cpu_irq;
  logic [N_CH-1:0]  req, busy, err;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  irq_dma_steer #(.N_SRC(N_SRC), .N_CH(N_CH), .DATA_W(DW)) i_irq_dma_steer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .nmi_i       (nmi),
    .src_irq_i   (src),
    .xfer_done_i (done),
    .cpu_irq_o   (cpu_irq),
    .dma_req_o   (req),
    .ch_busy_o   (busy),
    .ch_err_o    (err)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int addr, int data);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = DW'(data);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic finish_clean(int ch);
    done[ch] = 1'b1;
    tick();
    done[ch] = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=running expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1: reset state passes everything to the CPU
    src = 4'b1010;
    #1;
    chk("R1 cpu_irq", 32'(cpu_irq), 32'hA);
    chk("R1 req", 32'(req), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 err", 32'(err), 0);
    src = '0;
    tick();

    // Sweep: R2 R3 R4 R5 R9 R12 R13
    for (int en = 0; en < 2; en++) begin
      for (int run = 0; run < 2; run++) begin
        for (int ch = 0; ch < N_CH; ch++) begin
          for (int s = 0; s < N_SRC; s++) begin
            int exp_act;
            exp_act = en & run;
            wr(0, run);
            wr(1 + (1 - ch), 0);
            wr(1 + ch, (s << 1) | en);
            src[s] = 1'b1;
            #1;
            chk(en ? "R3 claimed src masked" : "R2 src forwarded",
                32'(cpu_irq), en ? 0 : (1 << s));
            tick();
            chk(run ? "R4 pulse" : "R5 halted no pulse", 32'(req), exp_act << ch);
            chk("R9 busy set", 32'(busy), exp_act << ch);
            tick();
            chk("R12 held level one pulse", 32'(req), 0);
            src[s] = 1'b0;
            finish_clean(ch);
            chk("R9 busy cleared by done", 32'(busy), 0);
            chk("R5 no error", 32'(err), 0);
            wr(1 + ch, 0);
          end
        end
      end
    end

    // R10: overrun while busy
    wr(0, 1);
    wr(1, (1 << 1) | 1);
    src[1] = 1'b1; tick();
    chk("R10 first pulse", 32'(req), 1);
    src[1] = 1'b0; tick();
    src[1] = 1'b1; tick();
    chk("R10 no pulse when busy", 32'(req), 0);
    chk("R10 err set", 32'(err), 1);
    src[1] = 1'b0;
    finish_clean(0);
    chk("R10 busy cleared", 32'(busy), 0);
    chk("R10 err sticky", 32'(err), 1);
    src[1] = 1'b1; tick();
    chk("R10 err blocks", 32'(req), 0);
    src[1] = 1'b0; tick();
    wr(1, (1 << 1) | 0);
    tick();
    chk("R10 err cleared by disable", 32'(err), 0);
    wr(1, (1 << 1) | 1);
    src[1] = 1'b1; tick();
    chk("R10 accepts after clear", 32'(req), 1);
    src[1] = 1'b0;
    finish_clean(0);

    // R6: nmi beats a same-cycle write of master enable
    nmi = 1'b1; wr(0, 1); nmi = 1'b0;
    src[1] = 1'b1;
    #1;
    chk("R6 halted no cpu irq", 32'(cpu_irq), 0);
    tick();
    chk("R6 halted no pulse", 32'(req), 0);
    chk("R6 halted no busy", 32'(busy), 0);
    src[1] = 1'b0; tick();

    // R7: disable restores cpu delivery
    wr(1, (1 << 1) | 0);
    src[1] = 1'b1;
    #1;
    chk("R7 cpu restored", 32'(cpu_irq), 2);
    src[1] = 1'b0; tick();

    // R11: resume after master enable written back
    wr(1, (1 << 1) | 1);
    wr(0, 1);
    src[1] = 1'b1; tick();
    chk("R11 resumed pulse", 32'(req), 1);
    src[1] = 1'b0;
    finish_clean(0);

    // R8: one source activates both channels
    wr(1, (2 << 1) | 1);
    wr(2, (2 << 1) | 1);
    src[2] = 1'b1;
    #1;
    chk("R8 cpu masked", 32'(cpu_irq), 0);
    tick();
    chk("R8 both pulse", 32'(req), 3);
    src[2] = 1'b0;
    done = 2'b11; tick(); done = '0;
    chk("R8 both idle", 32'(busy), 0);

    // R13: unused address write has no effect
    wr(3, 0);
    src[2] = 1'b1;
    #1;
    chk("R13 unused addr keeps claim", 32'(cpu_irq), 0);
    tick();
    chk("R13 unused addr keeps run", 32'(req), 3);
    src[2] = 1'b0;
    done = 2'b11; tick(); done = '0;

    finished = 1'b1;
    summary();
  end
endmodule